// File: doc/BRIEF.md
# Frame and Superframe Sync Detector

This block sits after the symbol slicer of a two-bits-per-symbol line receiver. It receives one decoded quaternary symbol per strobe and finds the frame boundaries in that stream. Each frame starts with a short fixed sync word. The word may also be sent with every symbol negated, and that inverted form marks the first frame of a superframe.

From the spacing of the words the block builds basic frame alignment. While a frame is aligned, it pulses once at every frame boundary. It keeps that boundary running on its own through a few missing words. From the inverted word it derives superframe alignment and a frame index.

A loss-of-alignment report goes to the activation logic only after alignment has stayed away for a programmable number of symbols. That number is 38,400 by default, which is 480 ms at 80 ksymbol/s. A loss of the received signal drops alignment at once.

Top module: `fsd_sync_detector`

## Requirements
- R1: A symbol is 2 bits coded -3=00, -1=01, +1=10, +3=11, so negation is the bitwise inverse. The sync word is the 9 symbols +3 +3 -3 -3 -3 +3 -3 +3 +3 in arrival order. Either this word or its inverse counts as a sighting. A word with any symbol altered counts as neither.
- R2: `frame_locked` rises after ACQ_HITS sightings spaced exactly FRAME_LEN symbols apart. A missing sighting at the expected offset restarts the search.
- R3: `frame_start` is a one-cycle pulse. It is raised in the cycle after the last symbol of a boundary's word position, on lock entry and on every later boundary (including boundaries carried through a missing word). It is not raised on the boundary that drops lock.
- R4: Lock drops after MISS_LIMIT consecutive boundaries without a sighting. A sighting at a boundary clears the miss count.
- R5: `frame_idx` is 0 while unlocked. It advances by one at each boundary and wraps from SF_FRAMES to 1. It is forced to 1 at a boundary carrying the inverted word.
- R6: `sf_locked` rises at a boundary carrying the inverted word. It clears, with frame lock kept, when the inverted word arrives where the index would not be 1, or when the normal word arrives where it would be 1.
- R7: `loss_rpt` rises on the symbol after LOSS_SYMS symbols counted without lock. It clears while locked.
- R8: `sig_lost` forces, at the next edge, `frame_locked`=0, `sf_locked`=0, `frame_idx`=0 and `loss_rpt`=1.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | Symbol strobe |
| sym | input | 2 | Decoded symbol code |
| sig_lost | input | 1 | Loss of received signal |
| frame_locked | output | 1 | Basic frame alignment held |
| sf_locked | output | 1 | Superframe alignment held |
| frame_idx | output | $clog2(SF_FRAMES+1) | Frame number within superframe |
| frame_start | output | 1 | Frame boundary pulse |
| loss_rpt | output | 1 | Persistent loss report |

## Verification
The bench builds the block with FRAME_LEN=24, SF_FRAMES=4, ACQ_HITS=2, MISS_LIMIT=4 and LOSS_SYMS=100. With these values every corner of the block falls within a few thousand cycles:
- index wrap and a full superframe,
- both superframe mismatch cases,
- the flywheel through three missed words and the drop on the fourth,
- the exact symbol at which the loss report crosses its threshold.

A misaligned second sighting shows that acquisition needs the exact frame spacing.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    typedef enum logic [1:0] {
        Q_M3 = 2'b00,
        Q_M1 = 2'b01,
        Q_P1 = 2'b10,
        Q_P3 = 2'b11
    } quat_e;

    localparam int SYNC_LEN = 9;
    localparam int SYNC_W   = 2 * SYNC_LEN;

    // oldest symbol in the most significant position
    localparam logic [SYNC_W-1:0] SYNC_PAT = {
        Q_P3, Q_P3, Q_M3, Q_M3, Q_M3, Q_P3, Q_M3, Q_P3, Q_P3
    };

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } fsync_state_e;

    typedef struct packed {
        logic norm;
        logic inv;
    } sync_hit_t;

    function automatic logic [SYNC_W-1:0] sync_pattern(input logic inverted);
        return inverted ? ~SYNC_PAT : SYNC_PAT;
    endfunction

endpackage

// File: rtl/fsd_sym_window.sv
module fsd_sym_window
    import fsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      vld,
    input  logic [1:0] sym,
    output sync_hit_t hit
);
    localparam int HW = 2 * (SYNC_LEN - 1);

    logic [HW-1:0]     hist;
    logic [SYNC_W-1:0] cand;

    assign cand = {hist, sym};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= {(SYNC_LEN-1){Q_P1}};
        end else if (vld) begin
            hist <= cand[HW-1:0];
        end
    end

    always_comb begin
        hit.norm = vld && (cand == sync_pattern(1'b0));
        hit.inv  = vld && (cand == sync_pattern(1'b1));
    end

    a_r1_forms_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hit.norm && hit.inv));
endmodule

// File: rtl/fsd_frame_fsm.sv
module fsd_frame_fsm
    import fsd_pkg::*;
#(
    parameter int FRAME_LEN  = 120,
    parameter int ACQ_HITS   = 2,
    parameter int MISS_LIMIT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      vld,
    input  logic      sig_lost,
    input  sync_hit_t hit,
    output logic      locked,
    output logic      frame_start,
    output logic      fs_evt,
    output logic      lock_nx
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam int AW = $clog2(ACQ_HITS + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LAST     = CW'(FRAME_LEN - 1);
    localparam logic [AW-1:0] ACQ_N    = AW'(ACQ_HITS);
    localparam logic [MW-1:0] MISS_TOP = MW'(MISS_LIMIT - 1);

    fsync_state_e  st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [AW-1:0] acq, acq_n;
    logic [MW-1:0] miss, miss_n;
    logic          any_hit, at_exp;

    assign any_hit = hit.norm | hit.inv;
    assign at_exp  = vld && (cnt == LAST);

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        acq_n  = acq;
        miss_n = miss;
        if (vld) begin
            cnt_n = at_exp ? '0 : cnt + 1'b1;
        end
        case (st)
            ST_HUNT: begin
                if (any_hit) begin
                    cnt_n = '0;
                    if (ACQ_HITS <= 1) begin
                        st_n   = ST_LOCKED;
                        miss_n = '0;
                    end else begin
                        st_n  = ST_CONFIRM;
                        acq_n = AW'(1);
                    end
                end
            end
            ST_CONFIRM: begin
                if (at_exp) begin
                    if (any_hit) begin
                        acq_n = acq + 1'b1;
                        if (acq_n == ACQ_N) begin
                            st_n   = ST_LOCKED;
                            miss_n = '0;
                        end
                    end else begin
                        st_n  = ST_HUNT;
                        acq_n = '0;
                    end
                end
            end
            ST_LOCKED: begin
                if (at_exp) begin
                    if (any_hit) begin
                        miss_n = '0;
                    end else if (miss == MISS_TOP) begin
                        st_n   = ST_HUNT;
                        miss_n = '0;
                        acq_n  = '0;
                    end else begin
                        miss_n = miss + 1'b1;
                    end
                end
            end
            default: st_n = ST_HUNT;
        endcase
        if (sig_lost) begin
            st_n   = ST_HUNT;
            acq_n  = '0;
            miss_n = '0;
        end
    end

    assign lock_nx = (st_n == ST_LOCKED);
    assign fs_evt  = lock_nx && (at_exp || (vld && st != ST_LOCKED));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_HUNT;
            cnt         <= '0;
            acq         <= '0;
            miss        <= '0;
            locked      <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            st          <= st_n;
            cnt         <= cnt_n;
            acq         <= acq_n;
            miss        <= miss_n;
            locked      <= lock_nx;
            frame_start <= fs_evt;
        end
    end

    a_r3_start_only_locked: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> locked);
    a_r2_entry_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> frame_start);
    a_r4_drop_on_symbol: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(sig_lost)) |-> $past(vld));
    a_r8_sigloss_unlocks: assert property (@(posedge clk) disable iff (rst)
        sig_lost |=> !locked);
endmodule

// File: rtl/fsd_sf_tracker.sv
module fsd_sf_tracker
    import fsd_pkg::*;
#(
    parameter int SF_FRAMES = 8,
    parameter int IW        = $clog2(SF_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fs_evt,
    input  logic          lock_nx,
    input  sync_hit_t     hit,
    output logic [IW-1:0] idx,
    output logic          sf_locked
);
    localparam logic [IW-1:0] TOP = IW'(SF_FRAMES);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] pred;

    assign pred = (idx == TOP) ? ONE : idx + ONE;

    always_ff @(posedge clk) begin
        if (rst || !lock_nx) begin
            idx       <= '0;
            sf_locked <= 1'b0;
        end else if (fs_evt) begin
            if (hit.inv) begin
                idx       <= ONE;
                sf_locked <= !(sf_locked && pred != ONE);
            end else begin
                idx <= pred;
                if (hit.norm && sf_locked && pred == ONE) begin
                    sf_locked <= 1'b0;
                end
            end
        end
    end

    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx <= TOP);
    a_r6_sf_rise_at_one: assert property (@(posedge clk) disable iff (rst)
        $rose(sf_locked) |-> idx == ONE);
endmodule

// File: rtl/fsd_loss_timer.sv
module fsd_loss_timer #(
    parameter int LOSS_SYMS = 38400
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic locked,
    input  logic sig_lost,
    output logic rpt
);
    localparam int LW = $clog2(LOSS_SYMS + 1);
    localparam logic [LW-1:0] LIM = LW'(LOSS_SYMS);

    logic [LW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rpt <= 1'b0;
        end else if (sig_lost) begin
            rpt <= 1'b1;
        end else if (locked) begin
            cnt <= '0;
            rpt <= 1'b0;
        end else if (vld) begin
            if (cnt == LIM) begin
                rpt <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r8_sigloss_reports: assert property (@(posedge clk) disable iff (rst)
        sig_lost |=> rpt);
    a_r7_clear_while_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && !sig_lost) |=> !rpt);
endmodule

// File: rtl/fsd_sync_detector.sv
module fsd_sync_detector
    import fsd_pkg::*;
#(
    parameter int FRAME_LEN  = 120,
    parameter int SF_FRAMES  = 8,
    parameter int ACQ_HITS   = 2,
    parameter int MISS_LIMIT = 4,
    parameter int LOSS_SYMS  = 38400,
    parameter int IW         = $clog2(SF_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sym_vld,
    input  logic [1:0]    sym,
    input  logic          sig_lost,
    output logic          frame_locked,
    output logic          sf_locked,
    output logic [IW-1:0] frame_idx,
    output logic          frame_start,
    output logic          loss_rpt
);
    sync_hit_t hit;
    logic      fs_evt;
    logic      lock_nx;

    fsd_sym_window u_win (
        .clk (clk),
        .rst (rst),
        .vld (sym_vld),
        .sym (sym),
        .hit (hit)
    );

    fsd_frame_fsm #(
        .FRAME_LEN  (FRAME_LEN),
        .ACQ_HITS   (ACQ_HITS),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .vld         (sym_vld),
        .sig_lost    (sig_lost),
        .hit         (hit),
        .locked      (frame_locked),
        .frame_start (frame_start),
        .fs_evt      (fs_evt),
        .lock_nx     (lock_nx)
    );

    fsd_sf_tracker #(
        .SF_FRAMES (SF_FRAMES),
        .IW        (IW)
    ) u_sf (
        .clk       (clk),
        .rst       (rst),
        .fs_evt    (fs_evt),
        .lock_nx   (lock_nx),
        .hit       (hit),
        .idx       (frame_idx),
        .sf_locked (sf_locked)
    );

    fsd_loss_timer #(
        .LOSS_SYMS (LOSS_SYMS)
    ) u_loss (
        .clk      (clk),
        .rst      (rst),
        .vld      (sym_vld),
        .locked   (frame_locked),
        .sig_lost (sig_lost),
        .rpt      (loss_rpt)
    );

    a_r6_sf_needs_lock: assert property (@(posedge clk) disable iff (rst)
        sf_locked |-> frame_locked);
endmodule

// File: tb/fsd_sync_detector_tb_top.sv
module fsd_sync_detector_tb_top;
    localparam int FL   = 24;
    localparam int SF   = 4;
    localparam int LOSS = 100;
    localparam int IW   = $clog2(SF + 1);
    localparam int PAY  = FL - 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sym_vld = 1'b0;
    logic [1:0]    sym = 2'b10;
    logic          sig_lost = 1'b0;
    logic          frame_locked, sf_locked, frame_start, loss_rpt;
    logic [IW-1:0] frame_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic fs_seen;
    bit pay_tog = 1'b0;

    always #2 clk = ~clk;

    fsd_sync_detector #(
        .FRAME_LEN(FL), .SF_FRAMES(SF), .ACQ_HITS(2),
        .MISS_LIMIT(4), .LOSS_SYMS(LOSS)
    ) dut_i (
        .clk(clk), .rst(rst), .sym_vld(sym_vld), .sym(sym),
        .sig_lost(sig_lost), .frame_locked(frame_locked),
        .sf_locked(sf_locked), .frame_idx(frame_idx),
        .frame_start(frame_start), .loss_rpt(loss_rpt)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R1 coding: -3=00, -1=01, +1=10, +3=11
    function automatic logic [1:0] code(input int v);
        case (v)
            -3: return 2'b00;
            -1: return 2'b01;
             1: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    task automatic push(input logic [1:0] q);
        @(negedge clk);
        sym = q;
        sym_vld = 1'b1;
        @(posedge clk);
        #1;
        sym_vld = 1'b0;
    endtask

    task automatic payload(input int n);
        for (int i = 0; i < n; i++) begin
            pay_tog = ~pay_tog;
            push(code(pay_tog ? 1 : -1));
        end
    endtask

    // kind: 0 normal word, 1 inverted word, 2 corrupted word
    task automatic frame(input int kind);
        int w[9] = '{3, 3, -3, -3, -3, 3, -3, 3, 3};
        for (int i = 0; i < 9; i++) begin
            int v = (kind == 1) ? -w[i] : w[i];
            if (kind == 2 && i == 0) v = 1;
            push(code(v));
        end
        fs_seen = frame_start;
        payload(PAY);
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        chk(frame_locked, 0, "R9 locked after reset");
        chk(sf_locked, 0, "R9 sf after reset");
        chk(frame_idx, 0, "R9 idx after reset");
        chk(frame_start, 0, "R9 start after reset");
        chk(loss_rpt, 0, "R9 loss after reset");
    endtask

    task automatic t_acquire;
        frame(0);
        chk(fs_seen, 0, "R3 no pulse on first sighting");
        chk(frame_locked, 0, "R2 one sighting not enough");
        frame(0);
        chk(fs_seen, 1, "R3 pulse on lock entry");
        chk(frame_locked, 1, "R2 locked after two sightings");
        chk(frame_idx, 1, "R5 idx at lock entry");
        chk(sf_locked, 0, "R6 no sf from normal word");
    endtask

    task automatic t_superframe;
        frame(1);
        chk(sf_locked, 1, "R6 sf set by inverted word");
        chk(frame_idx, 1, "R5 idx forced to 1");
        for (int k = 2; k <= SF; k++) begin
            frame(0);
            chk(frame_idx, k, "R5 idx advance");
        end
        frame(1);
        chk(frame_idx, 1, "R5 idx wrap at inverted");
        chk(sf_locked, 1, "R6 sf held on aligned inverted");
    endtask

    task automatic t_mismatch;
        frame(0);
        frame(1);
        chk(sf_locked, 0, "R6 sf drop on early inverted");
        chk(frame_locked, 1, "R6 frame lock kept");
        chk(frame_idx, 1, "R5 idx 1 after inverted");
        for (int k = 2; k <= SF; k++) frame(0);
        frame(1);
        chk(sf_locked, 1, "R6 sf reacquired");
        for (int k = 2; k <= SF; k++) frame(0);
        frame(0);
        chk(sf_locked, 0, "R6 sf drop on normal at idx 1");
        chk(frame_locked, 1, "R6 frame lock kept (2)");
        chk(frame_idx, 1, "R5 idx wraps to 1");
    endtask

    task automatic t_flywheel;
        frame(1);
        for (int k = 0; k < 3; k++) begin
            frame(2);
            chk(fs_seen, 1, "R3 pulse on missed boundary");
            chk(frame_locked, 1, "R4 held through misses");
        end
        frame(0);
        for (int k = 0; k < 3; k++) frame(2);
        chk(frame_locked, 1, "R4 hit cleared miss count");
        frame(2);
        chk(fs_seen, 0, "R3 no pulse on dropping boundary");
        chk(frame_locked, 0, "R4 drop on fourth miss");
        chk(frame_idx, 0, "R5 idx 0 when unlocked");
        chk(sf_locked, 0, "R6 sf 0 when unlocked");
        chk(loss_rpt, 0, "R7 no report yet");
    endtask

    task automatic t_loss;
        payload(LOSS - PAY);
        chk(loss_rpt, 0, "R7 no report at threshold");
        payload(1);
        chk(loss_rpt, 1, "R7 report past threshold");
    endtask

    task automatic t_sigloss;
        frame(1);
        frame(0);
        chk(frame_locked, 1, "R1 inverted sighting acquires");
        chk(loss_rpt, 0, "R7 report cleared by lock");
        frame(1);
        chk(sf_locked, 1, "R6 sf before signal loss");
        @(negedge clk);
        sig_lost = 1'b1;
        @(posedge clk);
        #1 sig_lost = 1'b0;
        chk(frame_locked, 0, "R8 lock dropped");
        chk(sf_locked, 0, "R8 sf dropped");
        chk(frame_idx, 0, "R8 idx cleared");
        chk(loss_rpt, 1, "R8 report at once");
    endtask

    task automatic t_misaligned;
        frame(0);
        payload(3);
        frame(0);
        chk(frame_locked, 0, "R2 off-offset sighting restarts");
        frame(0);
        chk(frame_locked, 1, "R2 lock after realigned pair");
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_superframe();
        t_mismatch();
        t_flywheel();
        t_loss();
        t_sigloss();
        t_misaligned();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule